// File: doc/BRIEF.md
# Combining Lane Load-Store Queue

This block sits between a vector lane's memory pipelines and the on-chip interconnect. Each cycle it can take one 8-byte load or store. It keeps the accepted requests in a deep queue and sends them to the fabric in the order they arrived. A new request can join a queued transaction when both fall in the same 32-byte sector and the transaction has not yet reached the head. This turns several neighbouring 8-byte accesses into one sector transaction with a 4-bit word mask.

Loads wait in the queue until the fabric answers. A response carries a tag that names the queue entry. On return, every enabled 8-byte word of the response goes to the destination register recorded for that word. The block also keeps one pending bit per lane register, and that bit is the lane's only interlock. Any consumer that reads a register with an outstanding load sees a stall until the data comes back.

Top module: `comb_lsq`

## Requirements
- R1: A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low exactly while all DEPTH queue slots are occupied.
- R2: Transactions leave in queue order, one per `fab_valid`/`fab_ready` handshake. `fab_sector` is request address bits [ADDRW-1:5]. Mask bit k is set for the word with address bits [4:3] == k. Store word k travels in `fab_wdata[64k+63:64k]`, and words that are not enabled are zero.
- R3: A request joins an existing entry when all of the following hold: the entry is the youngest open entry for the request's sector, the kinds are equal (load with load, store with store), the entry's mask bit for that word is clear, and the entry is not at the head.
- R4: Loads and stores never share an entry. A request that cannot join allocates a new entry, and that entry becomes the only open entry for the sector. So a later store never joins a store that is older than an intervening load to the same sector, and the reverse holds as well.
- R5: Once an entry is presented at the head it is closed: new requests to its sector allocate a fresh entry. While `fab_valid` is high and `fab_ready` is low, every fabric payload field holds steady.
- R6: `fab_tag` is the entry index, and indices run 0..DEPTH-1 and wrap. Suppose a response arrives with `rsp_valid` high and tag t. On the next cycle `wb_en` equals the mask of entry t, and `wb_dst` slice k and `wb_data[64k+63:64k]` give word k's destination register and response data.
- R7: Accepting a load sets the pending bit of its destination register. The bit is cleared in the same cycle that register's write-back appears on `wb_en`. If a new load to that register is accepted in that same cycle, the bit stays set.
- R8: `lane_stall` is high, with no clock delay, exactly when `rd_valid` is high and the pending bit of `rd_reg` is set.
- R9: After reset the queue is empty, `req_ready` is high, `fab_valid` is low, `wb_en` is zero and no register is pending.
- R10: Slots are freed in queue order. A store frees its slot once issued. A load keeps its slot until its response returns, so an unanswered older load holds back `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lane request present |
| req_ready | output | 1 | Queue can accept a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDRW | Byte address, 8-byte aligned |
| req_wdata | input | 64 | Store data |
| req_dst | input | log2(NREG) | Load destination register |
| fab_valid | output | 1 | Fabric transaction present |
| fab_ready | input | 1 | Fabric accepts transaction |
| fab_store | output | 1 | Transaction is a store |
| fab_sector | output | ADDRW-5 | 32-byte sector index |
| fab_mask | output | 4 | Enabled 8-byte words |
| fab_wdata | output | 256 | Store data per word |
| fab_tag | output | log2(DEPTH) | Queue entry index |
| rsp_valid | input | 1 | Load response present |
| rsp_tag | input | log2(DEPTH) | Entry the response belongs to |
| rsp_data | input | 256 | Sector data |
| wb_en | output | 4 | Register write-back enable per word |
| wb_dst | output | 4*log2(NREG) | Destination register per word |
| wb_data | output | 256 | Write-back data per word |
| rd_valid | input | 1 | Consumer reads a register |
| rd_reg | input | log2(NREG) | Register being read |
| lane_stall | output | 1 | Lane must stall |

## Verification
Three kinds of internal fault show up at different points. A corrupted open flag or sector match shows up one handshake later as a fabric transaction with the wrong mask, or as two transactions where one was due. A wrong stored destination shows up in the write-back one cycle after the response. A pending bit that clears too early drops `lane_stall` in the very cycle after the wrong write-back, while one that never clears holds the lane forever. Slot accounting errors appear as `req_ready` staying low, or rising, on the cycle after an in-order retirement that should or should not have happened.

// File: rtl/comb_lsq.sv
module comb_lsq #(
  parameter int DEPTH = 192,
  parameter int ADDRW = 32,
  parameter int NREG  = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int REGW = $clog2(NREG),
  localparam int SECW = ADDRW - 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDRW-1:0]  req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [REGW-1:0]   req_dst,
  output logic              fab_valid,
  input  logic              fab_ready,
  output logic              fab_store,
  output logic [SECW-1:0]   fab_sector,
  output logic [3:0]        fab_mask,
  output logic [255:0]      fab_wdata,
  output logic [IDXW-1:0]   fab_tag,
  input  logic              rsp_valid,
  input  logic [IDXW-1:0]   rsp_tag,
  input  logic [255:0]      rsp_data,
  output logic [3:0]        wb_en,
  output logic [4*REGW-1:0] wb_dst,
  output logic [255:0]      wb_data,
  input  logic              rd_valid,
  input  logic [REGW-1:0]   rd_reg,
  output logic              lane_stall
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  busy_q, sent_q, done_q, open_q, st_q;
  logic [SECW-1:0]   sec_q [DEPTH];
  logic [3:0]        msk_q [DEPTH];
  logic [255:0]      dat_q [DEPTH];
  logic [4*REGW-1:0] dst_q [DEPTH];
  logic [IDXW-1:0]   tail_q, head_q, ret_q;
  logic [CNTW-1:0]   cnt_q;
  logic [NREG-1:0]   pend_q;

  logic [SECW-1:0]   req_sec;
  logic [1:0]        req_w;
  logic [DEPTH-1:0]  same_sec, hit;
  logic [IDXW-1:0]   hit_idx;
  logic [NREG-1:0]   clr;
  logic              accept, merge, alloc, fire, retire;

  function automatic logic [IDXW-1:0] step(input logic [IDXW-1:0] p);
    return (p == IDXW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign req_sec    = req_addr[ADDRW-1:5];
  assign req_w      = req_addr[4:3];
  assign req_ready  = cnt_q != CNTW'(DEPTH);
  assign accept     = req_valid & req_ready;
  assign merge      = accept & (|hit);
  assign alloc      = accept & ~(|hit);

  assign fab_valid  = busy_q[head_q] & ~sent_q[head_q];
  assign fab_store  = st_q[head_q];
  assign fab_sector = sec_q[head_q];
  assign fab_mask   = msk_q[head_q];
  assign fab_wdata  = dat_q[head_q];
  assign fab_tag    = head_q;
  assign fire       = fab_valid & fab_ready;

  assign retire     = busy_q[ret_q] & done_q[ret_q];
  assign lane_stall = rd_valid & pend_q[rd_reg];

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      same_sec[i] = busy_q[i] & open_q[i] & (sec_q[i] == req_sec);
      hit[i] = same_sec[i] & (IDXW'(i) != head_q) & (st_q[i] == req_store)
             & ~msk_q[i][req_w];
      if (hit[i]) hit_idx = IDXW'(i);
    end
  end

  always_comb begin
    clr = '0;
    for (int k = 0; k < 4; k++)
      if (rsp_valid && msk_q[rsp_tag][k]) clr[dst_q[rsp_tag][k*REGW +: REGW]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0; sent_q <= '0; done_q <= '0; open_q <= '0; st_q <= '0;
      tail_q <= '0; head_q <= '0; ret_q <= '0; cnt_q <= '0;
      pend_q <= '0; wb_en <= '0; wb_dst <= '0; wb_data <= '0;
    end else begin
      if (alloc) begin
        for (int i = 0; i < DEPTH; i++)
          if (same_sec[i]) open_q[i] <= 1'b0;
        busy_q[tail_q] <= 1'b1;
        sent_q[tail_q] <= 1'b0;
        done_q[tail_q] <= 1'b0;
        open_q[tail_q] <= 1'b1;
        st_q[tail_q]   <= req_store;
        tail_q         <= step(tail_q);
      end
      if (fire) begin
        sent_q[head_q] <= 1'b1;
        open_q[head_q] <= 1'b0;
        if (st_q[head_q]) done_q[head_q] <= 1'b1;
        head_q <= step(head_q);
      end
      if (rsp_valid) done_q[rsp_tag] <= 1'b1;
      if (retire) begin
        busy_q[ret_q] <= 1'b0;
        ret_q <= step(ret_q);
      end
      cnt_q <= cnt_q + CNTW'(alloc) - CNTW'(retire);

      wb_en   <= rsp_valid ? msk_q[rsp_tag] : 4'b0;
      wb_dst  <= dst_q[rsp_tag];
      wb_data <= rsp_data;

      for (int r = 0; r < NREG; r++) begin
        if (accept && !req_store && req_dst == REGW'(r)) pend_q[r] <= 1'b1;
        else if (clr[r]) pend_q[r] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      sec_q[tail_q] <= req_sec;
      msk_q[tail_q] <= 4'b0001 << req_w;
      dat_q[tail_q] <= req_store ? (256'(req_wdata) << {req_w, 6'b0}) : '0;
      dst_q[tail_q] <= (4*REGW)'(req_dst) << (REGW * int'(req_w));
    end
    if (merge) begin
      msk_q[hit_idx][req_w] <= 1'b1;
      if (req_store) dat_q[hit_idx][{req_w, 6'b0} +: 64] <= req_wdata;
      else dst_q[hit_idx][REGW*int'(req_w) +: REGW] <= req_dst;
    end
  end
endmodule

// File: rtl/comb_lsq_chk.sv
module comb_lsq_chk #(
  parameter int DEPTH = 192,
  parameter int ADDRW = 32,
  parameter int NREG  = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int REGW = $clog2(NREG),
  localparam int SECW = ADDRW - 5,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [CNTW-1:0] cnt,
  input logic [NREG-1:0] pend,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_store,
  input logic [REGW-1:0] req_dst,
  input logic            fab_valid,
  input logic            fab_ready,
  input logic            fab_store,
  input logic [SECW-1:0] fab_sector,
  input logic [3:0]      fab_mask,
  input logic [255:0]    fab_wdata,
  input logic [IDXW-1:0] fab_tag,
  input logic            rsp_valid,
  input logic [3:0]      wb_en,
  input logic            lane_stall
);
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(DEPTH));

  p_mask_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fab_valid |-> fab_mask != 4'b0);

  p_hold_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fab_valid && !fab_ready) |=> (fab_valid && $stable(fab_store) && $stable(fab_sector)
      && $stable(fab_mask) && $stable(fab_wdata) && $stable(fab_tag)));

  p_wb_after_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en != 4'b0) |-> $past(rsp_valid));

  p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_store) |=> pend[$past(req_dst)]);

  p_stall_needs_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lane_stall |-> cnt != '0);
endmodule

bind comb_lsq comb_lsq_chk #(.DEPTH(DEPTH), .ADDRW(ADDRW), .NREG(NREG)) i_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .pend(pend_q),
  .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store), .req_dst(req_dst),
  .fab_valid(fab_valid), .fab_ready(fab_ready), .fab_store(fab_store),
  .fab_sector(fab_sector), .fab_mask(fab_mask), .fab_wdata(fab_wdata), .fab_tag(fab_tag),
  .rsp_valid(rsp_valid), .wb_en(wb_en), .lane_stall(lane_stall)
);

// File: tb/test_comb_lsq.sv
module test_comb_lsq;
  localparam int DEPTH = 6;
  localparam int ADDRW = 32;
  localparam int NREG  = 32;
  localparam int IDXW  = $clog2(DEPTH);
  localparam int REGW  = $clog2(NREG);
  localparam int SECW  = ADDRW - 5;

  localparam logic [63:0] DA = 64'h1111_2222_3333_4444;
  localparam logic [63:0] DB = 64'h5555_6666_7777_8888;
  localparam logic [63:0] DC = 64'h9999_AAAA_BBBB_CCCC;
  localparam logic [63:0] DD = 64'hDDDD_EEEE_FFFF_0001;

  localparam bit          RQ_ST [8] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] RQ_AD [8] = '{32'h100, 32'h108, 32'h110, 32'h118,
                                        32'h100, 32'h200, 32'h208, 32'h200};
  localparam logic [63:0] RQ_DT [8] = '{64'h0, 64'h0, 64'h0, DA, 64'h0, DB, DC, DD};
  localparam logic [4:0]  RQ_DS [8] = '{5'd1, 5'd2, 5'd3, 5'd0, 5'd4, 5'd0, 5'd0, 5'd0};

  localparam bit           EX_ST  [6] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [26:0]  EX_SEC [6] = '{27'd8, 27'd8, 27'd8, 27'd8, 27'd16, 27'd16};
  localparam logic [3:0]   EX_MSK [6] = '{4'b0001, 4'b0110, 4'b1000, 4'b0001, 4'b0011, 4'b0001};
  localparam logic [255:0] EX_DAT [6] = '{256'h0, 256'h0, {DA, 192'h0}, 256'h0,
                                          {128'h0, DC, DB}, {192'h0, DD}};
  localparam string        EX_REQ [6] = '{"R2", "R3", "R4", "R4", "R3", "R3"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_store = 1'b0;
  logic [ADDRW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [REGW-1:0] req_dst = '0;
  logic fab_valid, fab_ready = 1'b0, fab_store;
  logic [SECW-1:0] fab_sector;
  logic [3:0] fab_mask;
  logic [255:0] fab_wdata;
  logic [IDXW-1:0] fab_tag;
  logic rsp_valid = 1'b0;
  logic [IDXW-1:0] rsp_tag = '0;
  logic [255:0] rsp_data = '0;
  logic [3:0] wb_en;
  logic [4*REGW-1:0] wb_dst;
  logic [255:0] wb_data;
  logic rd_valid = 1'b0;
  logic [REGW-1:0] rd_reg = '0;
  logic lane_stall;

  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  comb_lsq #(.DEPTH(DEPTH), .ADDRW(ADDRW), .NREG(NREG)) i_comb_lsq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_addr(req_addr), .req_wdata(req_wdata), .req_dst(req_dst),
    .fab_valid(fab_valid), .fab_ready(fab_ready), .fab_store(fab_store),
    .fab_sector(fab_sector), .fab_mask(fab_mask), .fab_wdata(fab_wdata), .fab_tag(fab_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .wb_en(wb_en), .wb_dst(wb_dst), .wb_data(wb_data),
    .rd_valid(rd_valid), .rd_reg(rd_reg), .lane_stall(lane_stall)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stall_is(input string req, input int r, input bit exp);
    rd_valid = 1'b1;
    rd_reg = REGW'(r);
    #1;
    chk(req, 256'(lane_stall), 256'(exp));
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_req(input logic [31:0] a, input int d);
    req_valid = 1'b1; req_store = 1'b0; req_addr = a; req_dst = REGW'(d); req_wdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R9 ready", 256'(req_ready), 256'(1));
    chk("R9 fab_valid", 256'(fab_valid), 256'(0));
    chk("R9 wb_en", 256'(wb_en), 256'(0));
    stall_is("R9 no pending", 1, 1'b0);
    rd_valid = 1'b0;

    for (int i = 0; i < 8; i++) begin
      chk("R1 ready while room", 256'(req_ready), 256'(1));
      req_valid = 1'b1; req_store = RQ_ST[i]; req_addr = RQ_AD[i];
      req_wdata = RQ_DT[i]; req_dst = RQ_DS[i];
      tick();
    end
    req_valid = 1'b0;
    chk("R1 full", 256'(req_ready), 256'(0));
    for (int r = 1; r <= 4; r++) stall_is("R7 pending after load", r, 1'b1);
    stall_is("R8 idle register", 5, 1'b0);
    rd_valid = 1'b0; rd_reg = REGW'(1); #1;
    chk("R8 no read", 256'(lane_stall), 256'(0));

    fab_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      chk(EX_REQ[k], 256'(fab_valid), 256'(1));
      chk(EX_REQ[k], 256'(fab_store), 256'(EX_ST[k]));
      chk(EX_REQ[k], 256'(fab_sector), 256'(EX_SEC[k]));
      chk(EX_REQ[k], 256'(fab_mask), 256'(EX_MSK[k]));
      chk(EX_REQ[k], fab_wdata, EX_DAT[k]);
      chk("R6 tag", 256'(fab_tag), 256'(k));
      tick();
    end
    fab_ready = 1'b0;
    chk("R2 drained", 256'(fab_valid), 256'(0));
    chk("R10 load holds slot", 256'(req_ready), 256'(0));

    rsp_valid = 1'b1; rsp_tag = 3'd1;
    rsp_data = {64'hD3, 64'hD2, 64'hD1, 64'hD0};
    tick();
    rsp_valid = 1'b0;
    chk("R6 wb_en merged", 256'(wb_en), 256'(4'b0110));
    chk("R6 dst word1", 256'(wb_dst[REGW +: REGW]), 256'(2));
    chk("R6 dst word2", 256'(wb_dst[2*REGW +: REGW]), 256'(3));
    chk("R6 data word1", 256'(wb_data[64 +: 64]), 256'(64'hD1));
    chk("R6 data word2", 256'(wb_data[128 +: 64]), 256'(64'hD2));
    stall_is("R7 cleared on return", 2, 1'b0);
    stall_is("R7 other still pending", 1, 1'b1);
    chk("R10 head load unanswered", 256'(req_ready), 256'(0));

    rsp_valid = 1'b1; rsp_tag = 3'd0; rsp_data = {192'h0, 64'hE0};
    tick();
    rsp_valid = 1'b0;
    chk("R6 single word", 256'(wb_en), 256'(4'b0001));
    chk("R6 dst word0", 256'(wb_dst[0 +: REGW]), 256'(1));
    chk("R6 data word0", 256'(wb_data[0 +: 64]), 256'(64'hE0));
    tick();
    chk("R10 slot freed in order", 256'(req_ready), 256'(1));

    rsp_valid = 1'b1; rsp_tag = 3'd3; rsp_data = {192'h0, 64'hE3};
    tick();
    rsp_valid = 1'b0;
    chk("R6 dst reg4", 256'(wb_dst[0 +: REGW]), 256'(4));
    repeat (5) tick();
    for (int r = 1; r <= 4; r++) stall_is("R7 all returned", r, 1'b0);
    rd_valid = 1'b0;

    load_req(32'h300, 6);
    tick();
    load_req(32'h308, 7);
    chk("R6 wrapped tag", 256'(fab_tag), 256'(0));
    chk("R5 head sector", 256'(fab_sector), 256'(24));
    tick();
    req_valid = 1'b0;
    chk("R5 head closed", 256'(fab_mask), 256'(4'b0001));
    tick();
    chk("R5 held tag", 256'(fab_tag), 256'(0));
    chk("R5 held mask", 256'(fab_mask), 256'(4'b0001));
    fab_ready = 1'b1;
    tick();
    chk("R5 separate entry tag", 256'(fab_tag), 256'(1));
    chk("R5 separate entry mask", 256'(fab_mask), 256'(4'b0010));
    tick();
    fab_ready = 1'b0;
    chk("R2 empty", 256'(fab_valid), 256'(0));

    rsp_valid = 1'b1; rsp_tag = 3'd0; rsp_data = {192'h0, 64'hF0};
    load_req(32'h400, 6);
    tick();
    rsp_valid = 1'b0; req_valid = 1'b0;
    chk("R6 wb reg6", 256'(wb_dst[0 +: REGW]), 256'(6));
    stall_is("R7 set wins", 6, 1'b1);
    rsp_valid = 1'b1; rsp_tag = 3'd1; rsp_data = {128'h0, 64'hF1, 64'h0};
    tick();
    rsp_valid = 1'b0;
    chk("R6 wb word1", 256'(wb_en), 256'(4'b0010));
    chk("R6 wb reg7", 256'(wb_dst[REGW +: REGW]), 256'(7));
    stall_is("R7 reg7 clear", 7, 1'b0);
    fab_ready = 1'b1;
    tick();
    fab_ready = 1'b0;
    rsp_valid = 1'b1; rsp_tag = 3'd2; rsp_data = {192'h0, 64'hF2};
    tick();
    rsp_valid = 1'b0;
    chk("R6 data second load", 256'(wb_data[0 +: 64]), 256'(64'hF2));
    stall_is("R7 reg6 clear", 6, 1'b0);
    rd_valid = 1'b0;
    repeat (4) tick();
    chk("R10 all freed", 256'(req_ready), 256'(1));

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule